// File: doc/BRIEF.md
# SD SPI Block Read Receiver

This block sits on the host side of an SD card link that runs over SPI. It starts once the card has accepted a read command. The receiver watches the incoming byte stream for the token that opens a block, then passes the payload bytes out one at a time. It checks the 16-bit CRC that follows the block and reports a pass or a fail. If the card sends a data-error token instead of a block, the receiver reports the card's error flags and ends the transfer. A programmable limit on idle bytes stops a transfer when no token arrives.

A read can cover one block or several. In a multi-block read the receiver goes back to waiting for the next token after each CRC. Each block's CRC is checked on its own. A stop request ends the read, either at once or after the block in progress. The payload length is picked when the read starts: a full memory block, or the short block returned by a card register read.

The state machine has five states:

- IDLE: no transfer in progress.
- WAIT: looking for a token.
- DATA: taking in payload bytes.
- CRCH: taking in the high CRC byte.
- CRCL: taking in the low CRC byte.

Its transitions are:

- IDLE→WAIT: on start.
- WAIT→DATA: on a start token.
- WAIT→IDLE: on an error token, on timeout, or on a stop request.
- DATA→CRCH: on the last payload byte.
- CRCH→CRCL: on the next byte.
- CRCL→WAIT: when the read is multi-block and no stop is pending.
- CRCL→IDLE: otherwise.

Top module: `sdspi_rd_rx`

## Requirements
- R1: While waiting, the byte 0xFE opens a block. Any other byte whose upper three bits are not 000 is fill and produces no output.
- R2: Each payload byte appears on `dout_o`, with `dout_valid_o` high for one cycle, in the cycle after it is accepted. Bytes leave in arrival order, and the block's start token and CRC bytes are not passed out.
- R3: The block CRC is CRC16 with polynomial 0x1021 and initial value 0x0000, taken MSB-first over the payload only. The two bytes after the payload carry the received CRC, high byte first. One cycle after the low CRC byte, `blk_done_o` pulses and `crc_ok_o` is 1 if and only if the CRCs match.
- R4: The payload is 512 bytes when `reg_mode_i` is 0 at start and 16 bytes when it is 1.
- R5: While waiting, a byte whose upper three bits are 000 is an error token. It ends the transfer. One cycle later `err_o` pulses, `err_code_o` holds the byte's low five bits, `busy_o` is 0, and no data is output.
- R6: While waiting, when `tmo_lim_i` non-token bytes have arrived in a row, `tmo_o` pulses one cycle after the last of them and the transfer ends. `tmo_lim_i` must be nonzero and held stable while busy.
- R7: In a multi-block read the receiver returns to waiting after each block's CRC, and each block's CRC is checked on its own.
- R8: A stop request (`stop_i`) made while waiting ends the read in the next cycle. A stop request made during a block ends the read after that block's CRC.
- R9: Bytes that arrive while idle are ignored. A start pulse while busy is ignored, including its length select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin a read (pulse) |
| multi_i | input | 1 | Multi-block read, sampled at start |
| reg_mode_i | input | 1 | Short register block, sampled at start |
| stop_i | input | 1 | Stop request (pulse) |
| tmo_lim_i | input | TMO_W | Non-token byte limit while waiting |
| rx_byte_i | input | 8 | Byte received from the card |
| rx_valid_i | input | 1 | rx_byte_i valid this cycle |
| dout_o | output | 8 | Payload byte out |
| dout_valid_o | output | 1 | dout_o valid |
| blk_done_o | output | 1 | Block finished (pulse) |
| crc_ok_o | output | 1 | CRC match for the finished block |
| err_o | output | 1 | Error token seen (pulse) |
| err_code_o | output | 5 | Error flags from the token |
| tmo_o | output | 1 | Token wait timed out (pulse) |
| busy_o | output | 1 | Read in progress |

## Verification
A scoreboard checks payload bytes and per-block CRC verdicts. It is fed with several kinds of input:

- Blocks built from a stepped pattern that passes through 0xFE and 0xFF. These show that token values inside a payload are taken as data.
- Blocks with a corrupted CRC. These separate a real CRC check from a constant pass.
- Fill bytes before a token. These exercise the wait path.
- Error tokens and streams that time out. These separate the ways a transfer can end.
- Multi-block reads with a bad middle block, and with stops placed inside or between blocks. These show that each CRC is checked on its own and that a stop takes effect at the right point.
- Stray bytes sent while idle, and a second start sent while busy. These show that the receiver ignores them.

// File: rtl/sdspi_rd_pkg.sv
package sdspi_rd_pkg;
    typedef enum logic [2:0] {ST_IDLE, ST_WAIT, ST_DATA, ST_CRCH, ST_CRCL} rd_state_t;

    localparam logic [7:0] TOK_START = 8'hFE;

    // One byte through CRC16 (x^16+x^12+x^5+1), MSB first
    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[15] ^ b[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction
endpackage

// File: rtl/sdspi_rd_crc.sv
module sdspi_rd_crc
    import sdspi_rd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc_o
);
    logic [15:0] crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   crc_q <= '0;
        else if (clr) crc_q <= '0;
        else if (en)  crc_q <= crc16_step(crc_q, din);
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/sdspi_rd_wdog.sv
module sdspi_rd_wdog #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] lim,
    output logic         expire_o
);
    logic [W-1:0] cnt_q;

    assign expire_o = tick && (cnt_q == lim - W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (clr)      cnt_q <= '0;
        else if (expire_o) cnt_q <= '0;
        else if (tick)     cnt_q <= cnt_q + W'(1);
    end

    // R6: the count of fill bytes never reaches the limit
    assert_wdog_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lim != '0) |-> (cnt_q < lim));
endmodule

// File: rtl/sdspi_rd_rx.sv
module sdspi_rd_rx
    import sdspi_rd_pkg::*;
#(
    parameter int BLK_BYTES = 512,
    parameter int REG_BYTES = 16,
    parameter int TMO_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             multi_i,
    input  logic             reg_mode_i,
    input  logic             stop_i,
    input  logic [TMO_W-1:0] tmo_lim_i,
    input  logic [7:0]       rx_byte_i,
    input  logic             rx_valid_i,
    output logic [7:0]       dout_o,
    output logic             dout_valid_o,
    output logic             blk_done_o,
    output logic             crc_ok_o,
    output logic             err_o,
    output logic [4:0]       err_code_o,
    output logic             tmo_o,
    output logic             busy_o
);
    localparam int CW = $clog2(BLK_BYTES);

    rd_state_t   state_q, nxt;
    logic [CW-1:0] byte_cnt_q, len_last;
    logic        multi_q, reg_q, stop_pend_q;
    logic [7:0]  crc_hi_q;
    logic [15:0] crc_calc;
    logic        is_start, is_err, stop_now, expire, fill_tick;
    logic        dout_valid_q, blk_done_q, crc_ok_q, err_q, tmo_q;
    logic [7:0]  dout_q;
    logic [4:0]  err_code_q;

    assign is_start  = (rx_byte_i == TOK_START);
    assign is_err    = (rx_byte_i[7:5] == 3'b000);
    assign stop_now  = stop_i || stop_pend_q;
    assign len_last  = reg_q ? CW'(REG_BYTES - 1) : CW'(BLK_BYTES - 1);
    assign fill_tick = (state_q == ST_WAIT) && !stop_now && rx_valid_i && !is_start && !is_err;

    sdspi_rd_crc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q == ST_WAIT),
        .en    ((state_q == ST_DATA) && rx_valid_i),
        .din   (rx_byte_i),
        .crc_o (crc_calc)
    );

    sdspi_rd_wdog #(.W(TMO_W)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (state_q != ST_WAIT),
        .tick     (fill_tick),
        .lim      (tmo_lim_i),
        .expire_o (expire)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) nxt = ST_WAIT;
            ST_WAIT: begin
                if (stop_now)                    nxt = ST_IDLE;
                else if (rx_valid_i && is_start) nxt = ST_DATA;
                else if (rx_valid_i && is_err)   nxt = ST_IDLE;
                else if (expire)                 nxt = ST_IDLE;
            end
            ST_DATA: if (rx_valid_i && byte_cnt_q == len_last) nxt = ST_CRCH;
            ST_CRCH: if (rx_valid_i) nxt = ST_CRCL;
            ST_CRCL: if (rx_valid_i) nxt = (multi_q && !stop_now) ? ST_WAIT : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_cnt_q   <= '0;
            multi_q      <= 1'b0;
            reg_q        <= 1'b0;
            stop_pend_q  <= 1'b0;
            crc_hi_q     <= '0;
            dout_q       <= '0;
            dout_valid_q <= 1'b0;
            blk_done_q   <= 1'b0;
            crc_ok_q     <= 1'b0;
            err_q        <= 1'b0;
            err_code_q   <= '0;
            tmo_q        <= 1'b0;
        end else begin
            dout_valid_q <= 1'b0;
            blk_done_q   <= 1'b0;
            err_q        <= 1'b0;
            tmo_q        <= 1'b0;
            if (state_q == ST_IDLE) begin
                stop_pend_q <= 1'b0;
                if (start_i) begin
                    multi_q <= multi_i;
                    reg_q   <= reg_mode_i;
                end
            end else if (stop_i) begin
                stop_pend_q <= 1'b1;
            end
            if (state_q == ST_WAIT) byte_cnt_q <= '0;
            if (state_q == ST_WAIT && !stop_now && rx_valid_i && !is_start && is_err) begin
                err_q      <= 1'b1;
                err_code_q <= rx_byte_i[4:0];
            end
            if (expire) tmo_q <= 1'b1;
            if (state_q == ST_DATA && rx_valid_i) begin
                dout_q       <= rx_byte_i;
                dout_valid_q <= 1'b1;
                byte_cnt_q   <= byte_cnt_q + CW'(1);
            end
            if (state_q == ST_CRCH && rx_valid_i) crc_hi_q <= rx_byte_i;
            if (state_q == ST_CRCL && rx_valid_i) begin
                blk_done_q <= 1'b1;
                crc_ok_q   <= ({crc_hi_q, rx_byte_i} == crc_calc);
            end
        end
    end

    assign dout_o       = dout_q;
    assign dout_valid_o = dout_valid_q;
    assign blk_done_o   = blk_done_q;
    assign crc_ok_o     = crc_ok_q;
    assign err_o        = err_q;
    assign err_code_o   = err_code_q;
    assign tmo_o        = tmo_q;
    assign busy_o       = (state_q != ST_IDLE);

    // R2: payload bytes come only out of the data state
    assert_dout_from_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid_q |-> $past(state_q == ST_DATA));
    // R5: an error report leaves the receiver idle
    assert_err_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (state_q == ST_IDLE));
    // R3: at most one completion event per cycle
    assert_one_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_q, tmo_q, blk_done_q}));
    // R4: payload counter stays inside the selected length
    assert_len_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (byte_cnt_q <= len_last));
    // R7: block completion follows the low CRC byte
    assert_done_after_crc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done_q |-> $past(state_q == ST_CRCL));
    // R6: a timeout leaves the receiver idle
    assert_tmo_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_q |-> (state_q == ST_IDLE));
endmodule

// File: tb/sdspi_rd_rx_bench.sv
`timescale 1ns/1ps
module sdspi_rd_rx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, multi_i = 1'b0, reg_mode_i = 1'b0, stop_i = 1'b0;
    logic [15:0] tmo_lim_i = 16'd8;
    logic [7:0]  rx_byte_i = 8'hFF;
    logic        rx_valid_i = 1'b0;
    logic [7:0]  dout_o;
    logic        dout_valid_o, blk_done_o, crc_ok_o, err_o, tmo_o, busy_o;
    logic [4:0]  err_code_o;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_q[$];
    logic       res_q[$];

    always #2.5 clk = ~clk;

    sdspi_rd_rx u_sdspi_rd_rx (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .multi_i(multi_i),
        .reg_mode_i(reg_mode_i), .stop_i(stop_i), .tmo_lim_i(tmo_lim_i),
        .rx_byte_i(rx_byte_i), .rx_valid_i(rx_valid_i), .dout_o(dout_o),
        .dout_valid_o(dout_valid_o), .blk_done_o(blk_done_o), .crc_ok_o(crc_ok_o),
        .err_o(err_o), .err_code_o(err_code_o), .tmo_o(tmo_o), .busy_o(busy_o)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference CRC by long division of payload * x^16
    function automatic logic [15:0] ref_crc(input logic [7:0] d[], input int n);
        logic [15:0] r = '0;
        logic top;
        for (int i = 0; i < n * 8 + 16; i++) begin
            logic bitv;
            bitv = (i < n * 8) ? d[i / 8][7 - (i % 8)] : 1'b0;
            top = r[15];
            r = {r[14:0], bitv};
            if (top) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && dout_valid_o) begin
            if (exp_q.size() == 0) check(1'b0, "R2 unexpected byte", dout_o, 0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(dout_o == e, "R2 payload byte", dout_o, e);
            end
        end
        if (rst_n && blk_done_o) begin
            if (res_q.size() == 0) check(1'b0, "R7 unexpected block end", 1, 0);
            else begin
                logic e;
                e = res_q.pop_front();
                check(crc_ok_o == e, "R3 crc verdict", crc_ok_o, e);
            end
        end
    end

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_byte_i  = b;
        rx_valid_i = 1'b1;
        @(negedge clk);
        rx_valid_i = 1'b0;
        rx_byte_i  = 8'hFF;
    endtask

    task automatic begin_read(input logic multi, input logic regm);
        @(negedge clk);
        multi_i = multi; reg_mode_i = regm; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Send token, payload and CRC; optionally corrupt CRC; optional stop pulse mid-block
    task automatic send_block(input int n, input logic [7:0] seed, input logic corrupt,
                              input logic stop_mid);
        logic [7:0] d[];
        logic [15:0] c;
        d = new[n];
        for (int k = 0; k < n; k++) begin
            d[k] = seed + 8'(k * 7);
            exp_q.push_back(d[k]);
        end
        c = ref_crc(d, n);
        if (corrupt) c = c ^ 16'h0100;
        res_q.push_back(!corrupt);
        send_byte(8'hFE);
        for (int k = 0; k < n; k++) begin
            if (stop_mid && k == 3) stop_i = 1'b1;
            send_byte(d[k]);
            stop_i = 1'b0;
        end
        send_byte(c[15:8]);
        send_byte(c[7:0]);
    endtask

    initial begin
        #(200000 * 5);
        check(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy_o == 0 && dout_valid_o == 0 && err_o == 0, "R9 reset state", busy_o, 0);
        rst_n = 1'b1;

        // R9: bytes while idle are ignored
        send_byte(8'hFE); send_byte(8'h12); send_byte(8'h05);
        check(busy_o == 0 && dout_valid_o == 0 && err_o == 0, "R9 idle bytes ignored", busy_o, 0);

        // R1 R3 R4: full memory block with fill before token
        begin_read(1'b0, 1'b0);
        send_byte(8'hFF); send_byte(8'hFF); send_byte(8'hA5);
        check(busy_o == 1 && dout_valid_o == 0, "R1 fill bytes no output", busy_o, 1);
        send_block(512, 8'h03, 1'b0, 1'b0);
        check(busy_o == 0, "R4 512-byte block ends single read", busy_o, 0);
        check(exp_q.size() == 0, "R4 all 512 bytes delivered", exp_q.size(), 0);

        // R4: register block, 16 bytes
        begin_read(1'b0, 1'b1);
        send_block(16, 8'hF0, 1'b0, 1'b0);
        check(busy_o == 0, "R4 16-byte block length", busy_o, 0);

        // R3: corrupted CRC
        begin_read(1'b0, 1'b1);
        send_block(16, 8'h40, 1'b1, 1'b0);
        check(busy_o == 0, "R3 bad crc block ends", busy_o, 0);

        // R5: error token
        begin_read(1'b1, 1'b1);
        send_byte(8'hFF);
        send_byte(8'h09);
        check(err_o == 1, "R5 error pulse", err_o, 1);
        check(err_code_o == 5'h09, "R5 error code", err_code_o, 9);
        check(busy_o == 0, "R5 transfer ended", busy_o, 0);

        // R6: timeout after 5 non-token bytes
        tmo_lim_i = 16'd5;
        begin_read(1'b0, 1'b0);
        repeat (4) send_byte(8'hFF);
        check(tmo_o == 0 && busy_o == 1, "R6 no timeout before limit", tmo_o, 0);
        send_byte(8'h7A);
        check(tmo_o == 1 && busy_o == 0, "R6 timeout at limit", tmo_o, 1);
        tmo_lim_i = 16'd40;

        // R7 R8: three blocks, bad middle CRC, stop during third
        begin_read(1'b1, 1'b1);
        send_block(16, 8'h11, 1'b0, 1'b0);
        check(busy_o == 1, "R7 waits for next block", busy_o, 1);
        send_block(16, 8'h22, 1'b1, 1'b0);
        check(busy_o == 1, "R7 continues after bad crc", busy_o, 1);
        send_block(16, 8'h33, 1'b0, 1'b1);
        check(busy_o == 0, "R8 stop ends after block", busy_o, 0);

        // R8: stop while waiting
        begin_read(1'b1, 1'b1);
        send_block(16, 8'h55, 1'b0, 1'b0);
        @(negedge clk); stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
        check(busy_o == 0, "R8 stop while waiting", busy_o, 0);

        // R9: start while busy ignored (length stays 16)
        begin_read(1'b0, 1'b1);
        begin_read(1'b0, 1'b0);
        send_block(16, 8'h77, 1'b0, 1'b0);
        check(busy_o == 0, "R9 restart ignored", busy_o, 0);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0 && res_q.size() == 0, "R2 scoreboard drained",
              exp_q.size() + res_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule